// File: doc/BRIEF.md
# Programmable GPIO Port with Per-Bit Output Delay and Pulse Mode

This block is one general-purpose I/O port of up to 32 bits behind a simple register interface. Software picks a direction for each bit and writes the output value. A protect mask lets a single write set, clear or overwrite any chosen group of bits and leave the others alone. Each output bit can be held back by 0 to 3 clock cycles before it reaches the pad. Any bit can also run in pulse mode, where a written 1 lasts for one cycle and then drops.

Inputs pass through a two-flop synchronizer. One configuration bit bypasses it for the whole port, so each input is taken from a single register on the clock edge. Each bit can raise an interrupt. A per-bit mode bit chooses edge or level detection, and a per-bit polarity bit chooses rising or falling edge, or high or low level. Edge events set sticky flags that software clears by writing 1. All enabled statuses are ORed into one interrupt line.

Top module: `gpioPort`

## Requirements
- R1: While reset is active and right after it, padOe, padOut and irq are all 0, and every register reads 0.
- R2: After a write to the direction register (address 3), padOe equals the written value from the next clock edge on. A 1 bit means the pin is driven.
- R3: A write to the output register (address 0) changes only the bits whose protect-mask bit (address 4) is 0. Bits with a mask of 1 keep their value.
- R4: A write to the set register (address 1) sets the written 1 bits, and a write to the clear register (address 2) clears them. In both cases, bits with a mask of 1 are left unchanged.
- R5: Each bit of padOut copies its output-register bit, delayed by d clock cycles. The delay d is 2*hi+lo, where lo is that bit in address 6 and hi is that bit in address 7. A delay of 0 shows the new value right after the writing edge.
- R6: A bit whose pulse-mode bit (address 5) is 1 stays at 1 in the output register for exactly one cycle after a write makes it 1. It then returns to 0.
- R7: Address 12 reads the sampled input. With bit 0 of address 13 at 0, a pad change shows up after two clock edges. With that bit at 1, it shows up after one edge.
- R8: A bit in edge mode (address 9 bit = 1) sets a sticky flag on a rising edge when its polarity bit (address 10) is 1, or on a falling edge when it is 0. Writing 1 to that bit of address 11 clears the flag.
- R9: A bit in level mode (address 9 bit = 0) reports a status that follows the sampled input. The status is active while the input is high if the polarity bit is 1, or while it is low if the polarity bit is 0. Address 11 reads the per-bit status.
- R10: irq is the OR of all status bits whose enable bit (address 8) is 1. A disabled status never raises irq.
- R11: Reading address 0 returns the current output register. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wrData | input | W | Write data |
| rdData | output | W | Read data for addr (combinational) |
| padIn | input | W | Pad input values |
| padOut | output | W | Pad drive values after delay |
| padOe | output | W | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The write path is tested with overwrite, set and clear operations under several protect masks. This includes all-ones data against a partial mask, which separates masked bits from written bits. A staircase test gives four bits delays of 0 through 3 and writes them together, so each cycle shows exactly one new bit on the pads. Interrupt tests drive rising and falling input edges under both polarities, with edge and level modes side by side. They show that flags stay set, that levels follow the input, and that enables gate the output. The synchronizer is tested with and without bypass to tell one-edge latency from two-edge latency.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OUT   = 4'd0,
    A_SET   = 4'd1,
    A_CLR   = 4'd2,
    A_DIR   = 4'd3,
    A_MASK  = 4'd4,
    A_PULSE = 4'd5,
    A_DLYLO = 4'd6,
    A_DLYHI = 4'd7,
    A_IEN   = 4'd8,
    A_IMODE = 4'd9,
    A_IPOL  = 4'd10,
    A_ISTAT = 4'd11,
    A_IN    = 4'd12,
    A_CFG   = 4'd13
  } regAddrE;

  // strobes from decode to datapath
  typedef struct packed {
    logic outWr;
    logic outSet;
    logic outClr;
    logic flagClr;
  } strobeT;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  input  logic [W-1:0]      outVal,
  input  logic [W-1:0]      inVal,
  input  logic [W-1:0]      statusVal,
  output strobeT            stb,
  output logic [W-1:0]      dirReg,
  output logic [W-1:0]      maskReg,
  output logic [W-1:0]      pulseReg,
  output logic [W-1:0]      dlyLoReg,
  output logic [W-1:0]      dlyHiReg,
  output logic [W-1:0]      ienReg,
  output logic [W-1:0]      modeReg,
  output logic [W-1:0]      polReg,
  output logic              bypassReg,
  output logic [W-1:0]      rdData
);
  regAddrE addrE;
  assign addrE = regAddrE'(addr);

  always_comb begin
    stb         = '0;
    stb.outWr   = wrEn && (addrE == A_OUT);
    stb.outSet  = wrEn && (addrE == A_SET);
    stb.outClr  = wrEn && (addrE == A_CLR);
    stb.flagClr = wrEn && (addrE == A_ISTAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '0;
      maskReg   <= '0;
      pulseReg  <= '0;
      dlyLoReg  <= '0;
      dlyHiReg  <= '0;
      ienReg    <= '0;
      modeReg   <= '0;
      polReg    <= '0;
      bypassReg <= 1'b0;
    end else if (wrEn) begin
      case (addrE)
        A_DIR:   dirReg    <= wrData;
        A_MASK:  maskReg   <= wrData;
        A_PULSE: pulseReg  <= wrData;
        A_DLYLO: dlyLoReg  <= wrData;
        A_DLYHI: dlyHiReg  <= wrData;
        A_IEN:   ienReg    <= wrData;
        A_IMODE: modeReg   <= wrData;
        A_IPOL:  polReg    <= wrData;
        A_CFG:   bypassReg <= wrData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (addrE)
      A_OUT:   rdData = outVal;
      A_DIR:   rdData = dirReg;
      A_MASK:  rdData = maskReg;
      A_PULSE: rdData = pulseReg;
      A_DLYLO: rdData = dlyLoReg;
      A_DLYHI: rdData = dlyHiReg;
      A_IEN:   rdData = ienReg;
      A_IMODE: rdData = modeReg;
      A_IPOL:  rdData = polReg;
      A_ISTAT: rdData = statusVal;
      A_IN:    rdData = inVal;
      A_CFG:   rdData = {{(W-1){1'b0}}, bypassReg};
      default: rdData = '0;
    endcase
  end

  // R1: the cycle after reset releases, no pin is driven
  assert_oe_off_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dirReg == '0));

  // R2: a direction write lands on the next edge
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrE == A_DIR) |=> (dirReg == $past(wrData)));
endmodule

// File: rtl/gpioPortData.sv
module gpioPortData
  import gpioPortPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       stb,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] maskBits,
  input  logic [W-1:0] pulseEn,
  input  logic [W-1:0] dlyLo,
  input  logic [W-1:0] dlyHi,
  input  logic [W-1:0] ienBits,
  input  logic [W-1:0] modeBits,
  input  logic [W-1:0] polBits,
  input  logic         bypass,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] outVal,
  output logic [W-1:0] inVal,
  output logic [W-1:0] statusVal,
  output logic         irq
);
  localparam int STAGES = 3;

  logic [W-1:0] outReg, outNext, holdVal, wrOpen;
  logic [W-1:0] dlyStage [1:STAGES];
  logic [W-1:0] syncA, syncB, prevIn;
  logic [W-1:0] edgeHit, levelHit, flagReg, flagClrBits;

  // output register: pulse bits fall back to 0 unless rewritten
  assign holdVal = outReg & ~pulseEn;
  assign wrOpen  = ~maskBits;

  always_comb begin
    if (stb.outWr)       outNext = (holdVal & maskBits) | (wrData & wrOpen);
    else if (stb.outSet) outNext = holdVal | (wrData & wrOpen);
    else if (stb.outClr) outNext = holdVal & ~(wrData & wrOpen);
    else                 outNext = holdVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= outNext;
  end

  // delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 1; s <= STAGES; s++) dlyStage[s] <= '0;
    end else begin
      dlyStage[1] <= outReg;
      for (int s = 2; s <= STAGES; s++) dlyStage[s] <= dlyStage[s-1];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bitSel
    always_comb begin
      case ({dlyHi[b], dlyLo[b]})
        2'd0:    padOut[b] = outReg[b];
        2'd1:    padOut[b] = dlyStage[1][b];
        2'd2:    padOut[b] = dlyStage[2][b];
        default: padOut[b] = dlyStage[3][b];
      endcase
    end
  end

  // input sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevIn <= inVal;
    end
  end
  assign inVal = bypass ? syncA : syncB;

  // interrupt detection
  assign edgeHit     = (polBits & inVal & ~prevIn) | (~polBits & ~inVal & prevIn);
  assign levelHit    = ~(polBits ^ inVal);
  assign flagClrBits = stb.flagClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~flagClrBits) | (edgeHit & modeBits);
  end

  assign statusVal = (modeBits & flagReg) | (~modeBits & levelHit);
  assign irq       = |(statusVal & ienBits);
  assign outVal    = outReg;

  // R3/R4: protected bits keep their value across any data write
  assert_mask_protect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outWr || stb.outSet || stb.outClr) |=>
      (((outReg ^ $past(outReg)) & $past(maskBits) & ~$past(outReg & pulseEn)) == '0));

  // R6: a high pulse bit drops on the next edge when nothing writes
  assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(stb.outWr || stb.outSet || stb.outClr) && ((outReg & pulseEn) != '0)) |=>
      ((outReg & $past(outReg & pulseEn)) == '0));

  // R8: edge flags stay set until a clear strobe
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.flagClr |=> ((flagReg & $past(flagReg)) == $past(flagReg)));

  // R10: no enable, no interrupt
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ienBits == '0) |-> !irq);
endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData,
  input  logic [W-1:0]      padIn,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic              irq
);
  strobeT       stb;
  logic [W-1:0] dirReg, maskReg, pulseReg, dlyLoReg, dlyHiReg;
  logic [W-1:0] ienReg, modeReg, polReg;
  logic         bypassReg;
  logic [W-1:0] outVal, inVal, statusVal;

  gpioPortCtrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .outVal(outVal), .inVal(inVal), .statusVal(statusVal), .stb(stb),
    .dirReg(dirReg), .maskReg(maskReg), .pulseReg(pulseReg),
    .dlyLoReg(dlyLoReg), .dlyHiReg(dlyHiReg), .ienReg(ienReg),
    .modeReg(modeReg), .polReg(polReg), .bypassReg(bypassReg),
    .rdData(rdData)
  );

  gpioPortData #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .maskBits(maskReg), .pulseEn(pulseReg), .dlyLo(dlyLoReg), .dlyHi(dlyHiReg),
    .ienBits(ienReg), .modeBits(modeReg), .polBits(polReg), .bypass(bypassReg),
    .padIn(padIn), .padOut(padOut), .outVal(outVal), .inVal(inVal),
    .statusVal(statusVal), .irq(irq)
  );

  assign padOe = dirReg;
endmodule

// File: tb/gpioPort_tb.sv
module gpioPort_tb;
  localparam int W = 32;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData, padOut, padOe;
  logic [W-1:0] padIn = '0;
  logic         irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpioPort #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [71:0] VEC [0:NV-1] = '{
    {4'd4, 32'hFFFF0000, 4'd4, 32'hFFFF0000},
    {4'd0, 32'h12345678, 4'd0, 32'h00005678},
    {4'd4, 32'h00000000, 4'd4, 32'h00000000},
    {4'd1, 32'h00F00000, 4'd0, 32'h00F05678},
    {4'd2, 32'h00000070, 4'd0, 32'h00F05608},
    {4'd4, 32'h0000000F, 4'd4, 32'h0000000F},
    {4'd2, 32'hFFFFFFFF, 4'd0, 32'h00000008},
    {4'd1, 32'hFFFFFFFF, 4'd0, 32'hFFFFFFF8},
    {4'd4, 32'h00000000, 4'd0, 32'hFFFFFFF8},
    {4'd0, 32'h00000000, 4'd0, 32'h00000000}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the writing edge
  task automatic regWrite(input logic [3:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [W-1:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rv;
    idle(3);
    // R1: reset state
    check("R1 padOe in reset", padOe, '0);
    check("R1 padOut in reset", padOut, '0);
    check("R1 irq in reset", {31'd0, irq}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 padOe after reset", padOe, '0);
    regRead(4'd0, rv); check("R1 out reg after reset", rv, '0);
    regRead(4'd12, rv); check("R1 input reg after reset", rv, '0);
    regRead(4'd14, rv); check("R11 unused address", rv, '0);

    // table walk: R3 masked writes, R4 set/clear, R11 readback
    for (int v = 0; v < NV; v++) begin
      regWrite(VEC[v][71:68], VEC[v][67:36]);
      regRead(VEC[v][35:32], rv);
      check($sformatf("R3/R4/R11 vector %0d", v), rv, VEC[v][31:0]);
      @(negedge clk);
    end

    // R2: direction
    regWrite(4'd3, 32'h000000A5);
    check("R2 padOe after dir write", padOe, 32'h000000A5);

    // R5: delay staircase, bit0..3 delay 0..3
    regWrite(4'd6, 32'h0000000A);
    regWrite(4'd7, 32'h0000000C);
    regWrite(4'd0, 32'h0000000F);
    check("R5 delay edge 0", padOut & 32'hF, 32'h1);
    @(negedge clk); check("R5 delay edge 1", padOut & 32'hF, 32'h3);
    @(negedge clk); check("R5 delay edge 2", padOut & 32'hF, 32'h7);
    @(negedge clk); check("R5 delay edge 3", padOut & 32'hF, 32'hF);
    regWrite(4'd6, 32'h0);
    regWrite(4'd7, 32'h0);
    regWrite(4'd0, 32'h0);

    // R6: pulse mode on bit0, bit1 normal
    regWrite(4'd5, 32'h00000001);
    regWrite(4'd1, 32'h00000003);
    check("R6 pulse high cycle", padOut & 32'h3, 32'h3);
    @(negedge clk);
    check("R6 pulse returned low", padOut & 32'h3, 32'h2);
    regRead(4'd0, rv); check("R6 out reg after pulse", rv & 32'h3, 32'h2);
    regWrite(4'd5, 32'h0);
    regWrite(4'd0, 32'h0);

    // R7: synchronized input, two edges
    padIn = 32'h1;
    regRead(4'd12, rv);
    @(negedge clk); regRead(4'd12, rv); check("R7 sync after 1 edge", rv & 32'h1, 32'h0);
    @(negedge clk); regRead(4'd12, rv); check("R7 sync after 2 edges", rv & 32'h1, 32'h1);
    // bypass: one edge
    regWrite(4'd13, 32'h1);
    padIn = 32'h0;
    @(negedge clk); regRead(4'd12, rv); check("R7 bypass after 1 edge", rv & 32'h1, 32'h0);
    regWrite(4'd13, 32'h0);
    idle(3);

    // R8: rising edge flag on bit4
    regWrite(4'd9, 32'h00000010);
    regWrite(4'd10, 32'h00000010);
    regWrite(4'd8, 32'h00000010);
    regWrite(4'd11, 32'hFFFFFFFF);
    check("R10 irq idle", {31'd0, irq}, 32'h0);
    padIn = 32'h10;
    idle(4);
    check("R8 rising flag irq", {31'd0, irq}, 32'h1);
    padIn = 32'h0;
    idle(4);
    regRead(4'd11, rv); check("R8 flag sticky after fall", rv & 32'h10, 32'h10);
    regWrite(4'd11, 32'h10);
    regRead(4'd11, rv); check("R8 flag cleared", rv & 32'h10, 32'h0);
    check("R8 irq after clear", {31'd0, irq}, 32'h0);
    // falling polarity
    regWrite(4'd10, 32'h0);
    padIn = 32'h10;
    idle(4);
    regRead(4'd11, rv); check("R8 no flag on rise with falling pol", rv & 32'h10, 32'h0);
    padIn = 32'h0;
    idle(4);
    regRead(4'd11, rv); check("R8 flag on fall", rv & 32'h10, 32'h10);
    regWrite(4'd11, 32'h10);
    regWrite(4'd8, 32'h0);
    regWrite(4'd9, 32'h0);

    // R9: level on bit5, high active
    regWrite(4'd10, 32'h00000020);
    regWrite(4'd8, 32'h00000020);
    check("R9 level high idle", {31'd0, irq}, 32'h0);
    padIn = 32'h20;
    idle(3);
    check("R9 level high active", {31'd0, irq}, 32'h1);
    padIn = 32'h0;
    idle(3);
    check("R9 level follows low", {31'd0, irq}, 32'h0);
    regWrite(4'd10, 32'h0);
    check("R9 low-active level", {31'd0, irq}, 32'h1);
    // R10: disable gates irq while status stays
    regWrite(4'd8, 32'h0);
    check("R10 disabled irq", {31'd0, irq}, 32'h0);
    regRead(4'd11, rv); check("R10 status still visible", rv & 32'h20, 32'h20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule